// File: doc/BRIEF.md
# USB Alternate-Setting Request Responder

This block sits in the control-endpoint logic of a USB device controller and answers the two standard requests that read and select an interface's alternate setting, without help from firmware. Software programs two 8-bit registers over a small register bus. The range register sets how many interfaces exist and whether automatic handling is on. The link register attaches up to two multi-setting groups to interfaces. One group allows settings 0 to 4 and the other allows settings 0 to 1. Every other valid interface allows only setting 0.

For each setup request the controller gives a one-cycle strobe together with bRequest, wValue and wIndex. One cycle later the block raises either an acknowledge or a stall. An acknowledged select-setting request updates the stored current setting of that interface. An acknowledged read-setting request returns that stored value as a one-byte response. A USB bus reset clears all stored settings to 0 and leaves the configuration registers unchanged.

Top module: `usb_altset_responder`

## Requirements
- R1: After reset both configuration registers read 00h (reg_addr 0 is the range register, reg_addr 1 is the link register), and resp_ack and resp_stall are 0.
- R2: In the range register, bit 7 enables automatic handling and bits 2:0 hold N, which makes interfaces 0 to N+1 valid. While bit 7 is 0, no request produces resp_ack or resp_stall.
- R3: Only bRequest 0Ah (read setting) and 0Bh (select setting) are handled. Any other bRequest produces neither resp_ack nor resp_stall.
- R4: For a handled request with automatic handling enabled, exactly one of resp_ack and resp_stall is 1 in the cycle after the setup_valid strobe, and both are 0 when no strobe was given.
- R5: A read-setting request is acknowledged when the full 16-bit wIndex is at most N+1, with resp_data holding the stored setting of that interface. Otherwise it is stalled. resp_data is 00h when there is no acknowledged read.
- R6: Link register fields: bit 4 enables the two-setting group, bits 6:5 hold its interface code and bit 7 routes it to interface 0. Bit 0 enables the five-setting group, bits 2:1 hold its code and bit 3 routes it to interface 0.
- R7: Interface code 00, 01, 10 and 11 selects interface 1, 2, 3 and 4. When a group's route-to-interface-0 bit is 1, its code is ignored.
- R8: A group whose enable bit is 0 has no effect. A group whose target interface is above N+1 is treated as disabled.
- R9: A select-setting request with a valid wIndex is acknowledged when the 16-bit wValue is at most 4 (five-setting group interface), at most 1 (two-setting group interface) or 0 (any other interface). Otherwise it is stalled.
- R10: An acknowledged select-setting request stores wValue as that interface's current setting. A stalled request leaves every stored setting unchanged.
- R11: bus_reset clears every stored setting to 0 and leaves both configuration registers unchanged.
- R12: When both groups target the same interface, the five-setting group takes priority, so that interface allows settings 0 to 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_reset | input | 1 | USB bus reset; clears stored settings |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = range register, 1 = link register |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr |
| setup_valid | input | 1 | One-cycle setup request strobe |
| setup_req | input | 8 | bRequest |
| setup_value | input | 16 | wValue |
| setup_index | input | 16 | wIndex |
| resp_ack | output | 1 | Request acknowledged |
| resp_stall | output | 1 | Request stalled |
| resp_data | output | 8 | One-byte response to the read-setting request |

## Verification
The request decision is tried with several input patterns. Worked link layouts test the field positions and the code mapping. Route-to-interface-0 patterns that carry a junk code show whether the code is really ignored. Disabled groups and groups linked out of range check that unused fields have no effect. A layout with both groups on one interface checks the priority. Random mixes of register writes, bus resets and requests whose wIndex, wValue and bRequest fall on both sides of every limit are compared with a bench model. Read-setting requests after stalled select-setting requests show whether stored state changes only on an acknowledge.

// File: rtl/usb_alt_pkg.sv
package usb_alt_pkg;
    localparam int RANGE_W  = 3;
    localparam int NUM_IF   = (1 << RANGE_W) + 1;
    localparam int IFNUM_W  = $clog2(NUM_IF);
    localparam int ALT_W    = 3;
    localparam int FIVE_MAX = 4;
    localparam int TWO_MAX  = 1;

    localparam logic [7:0] REQ_GET_ALT = 8'h0A;
    localparam logic [7:0] REQ_SET_ALT = 8'h0B;

    // One nibble of the link register: {route_to_0, code[1:0], enable}
    typedef struct packed {
        logic       to_if0;
        logic [1:0] code;
        logic       en;
    } grp_cfg_t;

    typedef struct packed {
        logic [7:0] rng;
        logic [7:0] lnk;
    } cfg_t;

    function automatic logic [IFNUM_W-1:0] grp_target(grp_cfg_t g);
        logic [IFNUM_W-1:0] t;
        if (g.to_if0) t = '0;
        else          t = IFNUM_W'(g.code) + IFNUM_W'(1);
        return t;
    endfunction
endpackage

// File: rtl/alt_cfg_regs.sv
module alt_cfg_regs
    import usb_alt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_wr,
    input  logic       reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic [7:0] range_q,
    output logic [7:0] link_q
);
    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (reg_wr) begin
            if (reg_addr) cfg_d.lnk = reg_wdata;
            else          cfg_d.rng = reg_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign range_q   = cfg_q.rng;
    assign link_q    = cfg_q.lnk;
    assign reg_rdata = reg_addr ? cfg_q.lnk : cfg_q.rng;

    // R2
    range_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !reg_addr) |=> (range_q == $past(reg_wdata)));
    // R6
    link_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr) |=> (link_q == $past(reg_wdata)));
endmodule

// File: rtl/alt_limit_decode.sv
module alt_limit_decode
    import usb_alt_pkg::*;
#(
    parameter int N_IF  = NUM_IF,
    parameter int IDX_W = IFNUM_W,
    parameter int AW    = ALT_W
) (
    input  logic [7:0]                 range_q,
    input  logic [7:0]                 link_q,
    output logic [IDX_W-1:0]           last_if,
    output logic [N_IF-1:0][AW-1:0]    limit
);
    grp_cfg_t           g_two, g_five;
    logic [IDX_W-1:0]   t_two, t_five;
    logic               act_two, act_five;

    always_comb begin
        last_if  = IDX_W'(range_q[RANGE_W-1:0]) + IDX_W'(1);
        g_two    = grp_cfg_t'(link_q[7:4]);
        g_five   = grp_cfg_t'(link_q[3:0]);
        t_two    = grp_target(g_two);
        t_five   = grp_target(g_five);
        act_two  = g_two.en  && (t_two  <= last_if);
        act_five = g_five.en && (t_five <= last_if);
    end

    for (genvar i = 0; i < N_IF; i++) begin : g_lim
        always_comb begin
            if (act_five && (t_five == IDX_W'(i)))     limit[i] = AW'(FIVE_MAX);
            else if (act_two && (t_two == IDX_W'(i)))  limit[i] = AW'(TWO_MAX);
            else                                       limit[i] = '0;
        end
    end
endmodule

// File: rtl/alt_setting_store.sv
module alt_setting_store
    import usb_alt_pkg::*;
#(
    parameter int N_IF  = NUM_IF,
    parameter int IDX_W = IFNUM_W,
    parameter int AW    = ALT_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       bus_reset,
    input  logic                       wr_en,
    input  logic [IDX_W-1:0]           wr_idx,
    input  logic [AW-1:0]              wr_val,
    output logic [N_IF-1:0][AW-1:0]    cur
);
    typedef struct packed {
        logic [N_IF-1:0][AW-1:0] alt;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (bus_reset) begin
            st_d.alt = '0;
        end else if (wr_en) begin
            for (int i = 0; i < N_IF; i++) begin
                if (wr_idx == IDX_W'(i)) st_d.alt[i] = wr_val;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cur = st_q.alt;

    // R11
    bus_reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_reset |=> (cur == '0));
    // R10
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !bus_reset) |=> $stable(cur));
endmodule

// File: rtl/usb_altset_responder.sv
module usb_altset_responder
    import usb_alt_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_reset,
    input  logic        reg_wr,
    input  logic        reg_addr,
    input  logic [7:0]  reg_wdata,
    output logic [7:0]  reg_rdata,
    input  logic        setup_valid,
    input  logic [7:0]  setup_req,
    input  logic [15:0] setup_value,
    input  logic [15:0] setup_index,
    output logic        resp_ack,
    output logic        resp_stall,
    output logic [7:0]  resp_data
);
    localparam int N_IF  = NUM_IF;
    localparam int IDX_W = IFNUM_W;
    localparam int AW    = ALT_W;

    typedef struct packed {
        logic       ack;
        logic       stall;
        logic [7:0] data;
    } resp_t;

    logic [7:0]              range_q, link_q;
    logic [IDX_W-1:0]        last_if;
    logic [N_IF-1:0][AW-1:0] limit, cur;

    logic                    is_get, is_set, handle, idx_ok, get_ok, set_ok;
    logic [IDX_W-1:0]        idx_sel;
    logic                    wr_en;
    resp_t                   rsp_d, rsp_q;

    alt_cfg_regs u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .range_q   (range_q),
        .link_q    (link_q)
    );

    alt_limit_decode #(.N_IF(N_IF), .IDX_W(IDX_W), .AW(AW)) u_dec (
        .range_q (range_q),
        .link_q  (link_q),
        .last_if (last_if),
        .limit   (limit)
    );

    alt_setting_store #(.N_IF(N_IF), .IDX_W(IDX_W), .AW(AW)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_reset (bus_reset),
        .wr_en     (wr_en),
        .wr_idx    (idx_sel),
        .wr_val    (setup_value[AW-1:0]),
        .cur       (cur)
    );

    always_comb begin
        is_get  = (setup_req == REQ_GET_ALT);
        is_set  = (setup_req == REQ_SET_ALT);
        handle  = setup_valid && range_q[7] && (is_get || is_set);
        idx_ok  = (setup_index <= 16'(last_if));
        idx_sel = idx_ok ? setup_index[IDX_W-1:0] : '0;
        get_ok  = is_get && idx_ok;
        set_ok  = is_set && idx_ok && (setup_value <= 16'(limit[idx_sel]));
        wr_en   = handle && set_ok;

        rsp_d       = '0;
        rsp_d.ack   = handle && (get_ok || set_ok);
        rsp_d.stall = handle && !(get_ok || set_ok);
        if (handle && get_ok) rsp_d.data = 8'(cur[idx_sel]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign resp_ack   = rsp_q.ack;
    assign resp_stall = rsp_q.stall;
    assign resp_data  = rsp_q.data;

    // R4
    ack_stall_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(resp_ack && resp_stall));
    // R4
    resp_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_ack || resp_stall) |-> $past(setup_valid));
    // R4
    strobe_gets_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (setup_valid && range_q[7] && (is_get || is_set)) |=> (resp_ack || resp_stall));
    // R2
    disabled_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (setup_valid && !range_q[7]) |=> !(resp_ack || resp_stall));
    // R9
    set_ack_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_ack && $past(setup_req) == REQ_SET_ALT) |-> ($past(setup_value) <= 16'(FIVE_MAX)));
    // R5
    idx_range_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (handle && !idx_ok) |=> resp_stall);
endmodule

// File: tb/tb_usb_altset_responder.sv
module tb_usb_altset_responder;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        bus_reset = 0;
    logic        reg_wr = 0;
    logic        reg_addr = 0;
    logic [7:0]  reg_wdata = 0;
    logic [7:0]  reg_rdata;
    logic        setup_valid = 0;
    logic [7:0]  setup_req = 0;
    logic [15:0] setup_value = 0;
    logic [15:0] setup_index = 0;
    logic        resp_ack, resp_stall;
    logic [7:0]  resp_data;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    logic [7:0] m_range = 0, m_link = 0;
    int         m_cur [9];

    always #2 clk = ~clk;

    usb_altset_responder dut (
        .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .setup_valid(setup_valid), .setup_req(setup_req),
        .setup_value(setup_value), .setup_index(setup_index),
        .resp_ack(resp_ack), .resp_stall(resp_stall), .resp_data(resp_data)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog: run did not finish, actual %0d cycles expected fewer", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    function automatic int m_last();
        return int'(m_range[2:0]) + 1;
    endfunction

    function automatic int m_limit(int i);
        int t5, t2;
        t5 = m_link[3] ? 0 : int'(m_link[2:1]) + 1;
        t2 = m_link[7] ? 0 : int'(m_link[6:5]) + 1;
        if (m_link[0] && t5 <= m_last() && i == t5) return 4;
        if (m_link[4] && t2 <= m_last() && i == t2) return 1;
        return 0;
    endfunction

    task automatic check(string tag, logic [9:0] act, logic [9:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual ack/stall/data %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(logic a, logic [7:0] d);
        @(negedge clk);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 0;
        if (a) m_link = d; else m_range = d;
    endtask

    task automatic do_bus_reset();
        @(negedge clk);
        bus_reset = 1;
        @(negedge clk);
        bus_reset = 0;
        foreach (m_cur[i]) m_cur[i] = 0;
    endtask

    task automatic req(string tag, logic [7:0] r, logic [15:0] v, logic [15:0] x);
        logic       e_ack, e_stall, ok;
        logic [7:0] e_data;
        e_ack = 0; e_stall = 0; e_data = 0;
        if (m_range[7] && (r == 8'h0A || r == 8'h0B)) begin
            if (r == 8'h0A) begin
                ok = (int'(x) <= m_last());
                if (ok) e_data = 8'(m_cur[int'(x)]);
            end else begin
                ok = (int'(x) <= m_last()) && (int'(v) <= m_limit(int'(x)));
                if (ok) m_cur[int'(x)] = int'(v);
            end
            e_ack = ok; e_stall = !ok;
        end
        @(negedge clk);
        setup_valid = 1; setup_req = r; setup_value = v; setup_index = x;
        @(negedge clk);
        setup_valid = 0;
        check(tag, {resp_ack, resp_stall, resp_data}, {e_ack, e_stall, e_data});
    endtask

    initial begin
        void'($urandom(32'h1234_5EED));
        foreach (m_cur[i]) m_cur[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        reg_addr = 0; #1;
        check("R1 range reg", {2'b00, reg_rdata}, 10'h000);
        reg_addr = 1; #1;
        check("R1 link reg", {2'b00, reg_rdata}, 10'h000);
        check("R1 no response", {resp_ack, resp_stall, 8'h00}, 10'h000);

        // R2 automatic handling off
        req("R2 disabled get", 8'h0A, 0, 0);
        wr_reg(0, 8'h02);
        req("R2 enable bit clear", 8'h0B, 0, 1);

        // example layout: interfaces 0..3, link 15h
        wr_reg(0, 8'h82);
        wr_reg(1, 8'h15);
        req("R3 other request", 8'h06, 0, 0);
        req("R9 if1 set 1", 8'h0B, 1, 1);
        req("R9 if1 set 2", 8'h0B, 2, 1);
        req("R9 if3 set 4", 8'h0B, 4, 3);
        req("R9 if3 set 5", 8'h0B, 5, 3);
        req("R6 if0 set 1", 8'h0B, 1, 0);
        req("R9 if2 set 0", 8'h0B, 0, 2);
        req("R5 get if4 out of range", 8'h0A, 0, 4);
        req("R5 get if3", 8'h0A, 0, 3);
        req("R5 get high byte index", 8'h0A, 0, 16'h0103);
        req("R9 wide wValue", 8'h0B, 16'h0100, 3);
        req("R10 stalled set keeps", 8'h0A, 0, 1);

        // R7 route to interface 0, code ignored
        wr_reg(1, 8'h0F);
        req("R7 if0 set 4", 8'h0B, 4, 0);
        req("R7 if4 code ignored", 8'h0B, 1, 3);
        req("R7 get if0", 8'h0A, 0, 0);

        // R8 disabled group and out-of-range group
        wr_reg(1, 8'h64);
        req("R8 disabled five grp", 8'h0B, 1, 3);
        req("R8 disabled two grp", 8'h0B, 1, 4);
        wr_reg(0, 8'h87);
        wr_reg(1, 8'h77);
        req("R7 if4 two grp", 8'h0B, 1, 4);
        req("R7 if4 five grp", 8'h0B, 4, 4);
        wr_reg(0, 8'h81);
        wr_reg(1, 8'h07);
        req("R8 five grp beyond range", 8'h0B, 1, 4);

        // R12 both groups on one interface
        wr_reg(0, 8'h83);
        wr_reg(1, 8'h11);
        req("R12 priority set 3", 8'h0B, 3, 1);
        req("R12 priority get", 8'h0A, 0, 1);

        // R11 bus reset
        do_bus_reset();
        req("R11 cleared setting", 8'h0A, 0, 1);
        req("R11 cleared if0", 8'h0A, 0, 0);
        reg_addr = 1; #1;
        check("R11 link kept", {2'b00, reg_rdata}, {2'b00, m_link});
        reg_addr = 0; #1;
        check("R11 range kept", {2'b00, reg_rdata}, {2'b00, m_range});

        // random mix
        for (int n = 0; n < 1500; n++) begin
            int sel;
            logic [7:0]  r;
            logic [15:0] v, x;
            sel = int'($urandom_range(0, 99));
            if (sel < 4) begin
                wr_reg(0, {($urandom_range(0, 9) != 0), 4'b0, 3'($urandom())});
            end else if (sel < 9) begin
                wr_reg(1, 8'($urandom()));
            end else if (sel < 11) begin
                do_bus_reset();
            end else begin
                sel = int'($urandom_range(0, 9));
                r = (sel < 4) ? 8'h0A : (sel < 9) ? 8'h0B : 8'($urandom());
                v = ($urandom_range(0, 19) == 0) ? 16'($urandom()) : 16'($urandom_range(0, 6));
                x = ($urandom_range(0, 19) == 0) ? 16'($urandom()) : 16'($urandom_range(0, 10));
                if (r == 8'h0A)      req("R5 random get", r, v, x);
                else if (r == 8'h0B) req("R9 random set", r, v, x);
                else                 req("R3 random other", r, v, x);
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule